// File: doc/BRIEF.md
# Dual Reference Selector with Holdover Control

This controller sits in front of a jitter-cleaning loop and decides which of two reference clocks feeds it. Both references are sampled by a local oscillator clock. A shared window timer splits time into windows of `los_window + 1` local cycles. At the end of each window, a monitor for each input judges whether that input showed a rising edge. An input that stays silent for a whole window is flagged lost. It is trusted again only after a programmable number of consecutive windows that contain edges.

A four-way mode input picks how the reference is chosen: a software bit, two fast select pins, automatic fail-over, or forced holdover. The block enters holdover when no usable reference remains or when holdover is demanded. In holdover it freezes the tuning word that it passes through to the oscillator. It leaves holdover by itself once the wanted input is valid again. Every change of the active input goes through a settle interval before it takes effect. The reference divide word presented downstream always belongs to the input that is currently active.

The controller has three states:
- `ST_HOLD`: the reset state, in which the tuning word is frozen.
- `ST_TRACK`: a reference is in use and the tuning word follows the live value.
- `ST_SETTLE`: a new input is pending and is counted through the settle interval.

It has five transitions:
- TRACK to HOLD, on a holdover need.
- TRACK to SETTLE, when the target differs from the active input.
- SETTLE to TRACK, on commit.
- SETTLE to HOLD, on abort.
- HOLD to SETTLE, on recovery.

Top module: `refsel_hold_ctrl`

## Requirements
- R1: After reset, `los_flags` is 2'b11, `holdover` is 1, `active_sel` is 0 and `held_tune` is 0.
- R2: An input's LOS flag is set at the end of any window in which that input shows no rising edge. A window lasts `los_window + 1` local clock cycles, and LOS therefore rises no later than two windows plus synchronizer delay after the edges stop.
- R3: A lost input's LOS flag clears only at the end of the `good_windows`-th consecutive window that contains edges. A silent window restarts the count.
- R4: With `sel_mode` = 1 (pin mode), `sel_pins` = 2'b00 selects input 0, `sel_pins` = 2'b01 selects input 1, and `sel_pins[1]` = 1 demands holdover. With `sel_mode` = 0 (software mode), `man_sel` selects the input (0 is input 0, 1 is input 1).
- R5: With `sel_mode` = 2 (automatic), if the active input is lost while the other is valid, the selection moves to the other input and holdover stays 0.
- R6: In automatic mode, a cycle with both inputs lost puts `holdover` at 1 on the next clock, and `active_sel` keeps its value.
- R7: In software or pin mode, if the chosen input is lost, the block enters holdover on the next clock.
- R8: With `sel_mode` = 3, `holdover` is 1 from the next clock regardless of input validity. Leaving mode 3 with a valid target returns to tracking.
- R9: While `holdover` is 0, `held_tune` takes `tune_live` at each clock. While `holdover` is 1, `held_tune` stays at the value captured on entry.
- R10: `active_sel` changes only after the target has been steady for `SETTLE_CYC` cycles in `ST_SETTLE`. From tracking, the change lands on the (`SETTLE_CYC`+1)-th clock after the target changes.
- R11: `ref_div` equals `div_word0` when `active_sel` is 0 and `div_word1` when it is 1.
- R12: Holdover is left automatically, through the settle interval, once the wanted input is valid and no holdover is demanded. `ST_TRACK` never coexists with `holdover` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oscillator clock |
| rst_n | input | 1 | Active-low reset |
| ref_in | input | 2 | Raw reference clock levels, bit i is input i |
| sel_mode | input | 2 | 0 software, 1 pins, 2 automatic, 3 forced holdover |
| man_sel | input | 1 | Software choice of input |
| sel_pins | input | 2 | Bit 0 chooses the input, bit 1 demands holdover |
| los_window | input | WIN_W | Window length minus one, in local cycles |
| good_windows | input | GOOD_W | Consecutive good windows needed to clear LOS |
| div_word0 | input | DIV_W | Reference divide value for input 0 |
| div_word1 | input | DIV_W | Reference divide value for input 1 |
| tune_live | input | TUNE_W | Live tuning word from the loop |
| active_sel | output | 1 | Active reference input |
| los_flags | output | 2 | Per-input loss-of-signal flags |
| holdover | output | 1 | Holdover state flag |
| held_tune | output | TUNE_W | Tuning word passed to the oscillator |
| ref_div | output | DIV_W | Divide value of the active input |

## Verification
Because both monitors share one window timer, loss detection on both inputs and an automatic switch-over can fall on the same clock edge. The controller must then go straight to holdover instead of starting a settle towards a dead input. The bench provokes this by driving both references from one common waveform and cutting them on the same cycle, so their last edges fall in the same window. It then judges that `holdover` rises, that `active_sel` is unchanged, and that `held_tune` ignores later changes of `tune_live`.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

    localparam int NUM_REFS = 2;

    typedef enum logic [1:0] {
        MODE_SOFT  = 2'd0,
        MODE_PINS  = 2'd1,
        MODE_AUTO  = 2'd2,
        MODE_FORCE = 2'd3
    } sel_mode_e;

    typedef enum logic [1:0] {
        ST_HOLD   = 2'd0,
        ST_TRACK  = 2'd1,
        ST_SETTLE = 2'd2
    } ctl_state_e;

endpackage

// File: rtl/refsel_win_timer.sv
module refsel_win_timer #(
    parameter int WIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIN_W-1:0] win_len,
    output logic             win_end
);

    logic [WIN_W-1:0] cnt_q;

    assign win_end = (cnt_q >= win_len);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (win_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Each closing window starts the next one from zero (R2).
    assert_window_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> (cnt_q == '0));

endmodule

// File: rtl/refsel_los_mon.sv
module refsel_los_mon #(
    parameter int GOOD_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_level,
    input  logic              win_end,
    input  logic [GOOD_W-1:0] need_good,
    output logic              lost
);

    logic              s_meta, s_sync, s_prev;
    logic              rise;
    logic              seen_q;
    logic              hit;
    logic [GOOD_W-1:0] good_q;
    logic [GOOD_W:0]   good_inc;

    assign rise     = s_sync & ~s_prev;
    assign hit      = seen_q | rise;
    assign good_inc = {1'b0, good_q} + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_meta <= 1'b0;
            s_sync <= 1'b0;
            s_prev <= 1'b0;
        end else begin
            s_meta <= ref_level;
            s_sync <= s_meta;
            s_prev <= s_sync;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            good_q <= '0;
            lost   <= 1'b1;
        end else if (win_end) begin
            seen_q <= 1'b0;
            if (!hit) begin
                lost   <= 1'b1;
                good_q <= '0;
            end else if (lost) begin
                if (good_inc >= {1'b0, need_good}) begin
                    lost   <= 1'b0;
                    good_q <= '0;
                end else begin
                    good_q <= good_inc[GOOD_W-1:0];
                end
            end
        end else if (rise) begin
            seen_q <= 1'b1;
        end
    end

    assert_los_rise_at_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lost) |-> $past(win_end));

    assert_los_clear_at_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lost) |-> $past(win_end));

endmodule

// File: rtl/refsel_fsm.sv
module refsel_fsm
    import refsel_pkg::*;
#(
    parameter int TUNE_W     = 16,
    parameter int SETTLE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_raw,
    input  logic              man_sel,
    input  logic [1:0]        sel_pins,
    input  logic [NUM_REFS-1:0] lost,
    input  logic [TUNE_W-1:0] tune_live,
    output logic              active_sel,
    output logic              holdover,
    output logic [TUNE_W-1:0] held_tune
);

    localparam int CNT_W = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

    sel_mode_e   mode;
    ctl_state_e  state_q, state_n;
    logic        pend_q, pend_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic        active_n, hold_n;
    logic        target;
    logic        need_hold;

    assign mode = sel_mode_e'(mode_raw);

    // Wanted input and holdover demand for the present mode.
    always_comb begin
        target    = active_sel;
        need_hold = 1'b0;
        unique case (mode)
            MODE_SOFT: begin
                target    = man_sel;
                need_hold = lost[man_sel];
            end
            MODE_PINS: begin
                target    = sel_pins[0];
                need_hold = sel_pins[1] | lost[sel_pins[0]];
            end
            MODE_AUTO: begin
                target    = lost[active_sel] ? ~active_sel : active_sel;
                need_hold = &lost;
            end
            MODE_FORCE: begin
                target    = active_sel;
                need_hold = 1'b1;
            end
        endcase
    end

    // Next-state logic.
    always_comb begin
        state_n  = state_q;
        pend_n   = pend_q;
        cnt_n    = cnt_q;
        active_n = active_sel;
        hold_n   = holdover;
        unique case (state_q)
            ST_TRACK: begin
                if (need_hold) begin
                    state_n = ST_HOLD;
                    hold_n  = 1'b1;
                end else if (target != active_sel) begin
                    state_n = ST_SETTLE;
                    pend_n  = target;
                    cnt_n   = '0;
                end
            end
            ST_SETTLE: begin
                if (need_hold) begin
                    state_n = ST_HOLD;
                    hold_n  = 1'b1;
                end else if (target != pend_q) begin
                    pend_n = target;
                    cnt_n  = '0;
                end else if (cnt_q == CNT_LAST) begin
                    state_n  = ST_TRACK;
                    active_n = pend_q;
                    hold_n   = 1'b0;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            ST_HOLD: begin
                if (!need_hold) begin
                    state_n = ST_SETTLE;
                    pend_n  = target;
                    cnt_n   = '0;
                end
            end
            default: begin
                state_n = ST_HOLD;
                hold_n  = 1'b1;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_HOLD;
            pend_q     <= 1'b0;
            cnt_q      <= '0;
            active_sel <= 1'b0;
            holdover   <= 1'b1;
        end else begin
            state_q    <= state_n;
            pend_q     <= pend_n;
            cnt_q      <= cnt_n;
            active_sel <= active_n;
            holdover   <= hold_n;
        end
    end

    // Output register: tuning word passes while tracking, freezes in holdover.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_tune <= '0;
        end else if (!holdover) begin
            held_tune <= tune_live;
        end
    end

    assert_sel_via_settle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_sel) |-> ($past(state_q) == ST_SETTLE));

    assert_tune_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (holdover && $past(holdover)) |-> $stable(held_tune));

    assert_force_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FORCE) |=> holdover);

    assert_auto_both_lost_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_AUTO) && (&lost)) |=> (holdover && $stable(active_sel)));

    assert_track_not_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRACK) |-> !holdover);

endmodule

// File: rtl/refsel_hold_ctrl.sv
module refsel_hold_ctrl
    import refsel_pkg::*;
#(
    parameter int WIN_W      = 8,
    parameter int GOOD_W     = 3,
    parameter int DIV_W      = 12,
    parameter int TUNE_W     = 16,
    parameter int SETTLE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        ref_in,
    input  logic [1:0]        sel_mode,
    input  logic              man_sel,
    input  logic [1:0]        sel_pins,
    input  logic [WIN_W-1:0]  los_window,
    input  logic [GOOD_W-1:0] good_windows,
    input  logic [DIV_W-1:0]  div_word0,
    input  logic [DIV_W-1:0]  div_word1,
    input  logic [TUNE_W-1:0] tune_live,
    output logic              active_sel,
    output logic [1:0]        los_flags,
    output logic              holdover,
    output logic [TUNE_W-1:0] held_tune,
    output logic [DIV_W-1:0]  ref_div
);

    logic win_end;
    logic [DIV_W-1:0] div_tab [NUM_REFS];

    refsel_win_timer #(.WIN_W(WIN_W)) win_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .win_len (los_window),
        .win_end (win_end)
    );

    for (genvar g = 0; g < NUM_REFS; g++) begin : g_mon
        refsel_los_mon #(.GOOD_W(GOOD_W)) mon_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .ref_level (ref_in[g]),
            .win_end   (win_end),
            .need_good (good_windows),
            .lost      (los_flags[g])
        );
    end

    refsel_fsm #(.TUNE_W(TUNE_W), .SETTLE_CYC(SETTLE_CYC)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_raw   (sel_mode),
        .man_sel    (man_sel),
        .sel_pins   (sel_pins),
        .lost       (los_flags),
        .tune_live  (tune_live),
        .active_sel (active_sel),
        .holdover   (holdover),
        .held_tune  (held_tune)
    );

    assign div_tab[0] = div_word0;
    assign div_tab[1] = div_word1;
    assign ref_div    = div_tab[active_sel];

endmodule

// File: tb/refsel_hold_ctrl_tb_top.sv
`timescale 1ns/1ps
module refsel_hold_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  ref_en;
    logic        base_wave;
    logic [1:0]  ref_in;
    logic [1:0]  sel_mode;
    logic        man_sel;
    logic [1:0]  sel_pins;
    logic [7:0]  los_window;
    logic [2:0]  good_windows;
    logic [11:0] div_word0, div_word1;
    logic [15:0] tune_live;
    logic        active_sel;
    logic [1:0]  los_flags;
    logic        holdover;
    logic [15:0] held_tune;
    logic [11:0] ref_div;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    // Common reference waveform, half period of 3 local cycles.
    int base_cnt = 0;
    always @(negedge clk) begin
        if (base_cnt == 2) begin
            base_cnt  <= 0;
            base_wave <= ~base_wave;
        end else begin
            base_cnt <= base_cnt + 1;
        end
    end
    assign ref_in = ref_en & {2{base_wave}};

    refsel_hold_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .sel_mode(sel_mode),
        .man_sel(man_sel), .sel_pins(sel_pins), .los_window(los_window),
        .good_windows(good_windows), .div_word0(div_word0), .div_word1(div_word1),
        .tune_live(tune_live), .active_sel(active_sel), .los_flags(los_flags),
        .holdover(holdover), .held_tune(held_tune), .ref_div(ref_div)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic bit exp_hold(input logic [1:0] m, input logic [1:0] pn);
        if (m == 2'd3) return 1'b1;
        if (m == 2'd1 && pn[1]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic exp_sel(input logic [1:0] m, input logic ms,
                                     input logic [1:0] pn, input logic prev);
        if (exp_hold(m, pn)) return prev;
        if (m == 2'd0) return ms;
        if (m == 2'd1) return pn[0];
        return prev;
    endfunction

    initial begin
        base_wave = 1'b0;
        ref_en = 2'b00; sel_mode = 2'd2; man_sel = 1'b0; sel_pins = 2'b00;
        los_window = 8'd15; good_windows = 3'd3;
        div_word0 = 12'd100; div_word1 = 12'd200; tune_live = 16'h1234;
        rst_n = 1'b0;
        wait_cyc(3);
        chk("R1 los", los_flags, 2'b11);
        chk("R1 holdover", holdover, 1);
        chk("R1 sel", active_sel, 0);
        chk("R1 tune", held_tune, 0);
        rst_n = 1'b1;

        // Both references start; automatic mode leaves holdover on input 0.
        ref_en = 2'b11;
        wait_cyc(90);
        chk("R3 both valid", los_flags, 2'b00);
        chk("R12 left hold", holdover, 0);
        chk("R5 auto sel", active_sel, 0);
        chk("R11 div0", ref_div, 100);
        chk("R9 tracking", held_tune, 16'h1234);

        // LOS timing on input 1.
        ref_en = 2'b01;
        wait_cyc(40);
        chk("R2 los1 set", los_flags[1], 1);
        chk("R2 no hold", holdover, 0);
        ref_en = 2'b11;
        wait_cyc(28);
        chk("R3 los1 not early", los_flags[1], 1);
        wait_cyc(44);
        chk("R3 los1 clear", los_flags[1], 0);

        // Automatic switch-over.
        ref_en = 2'b10;
        wait_cyc(40);
        chk("R2 los0 set", los_flags[0], 1);
        wait_cyc(6);
        chk("R5 switched", active_sel, 1);
        chk("R5 no hold", holdover, 0);
        chk("R11 div1", ref_div, 200);

        // Both lost in the same window.
        ref_en = 2'b11;
        wait_cyc(80);
        chk("R5 stays", active_sel, 1);
        ref_en = 2'b00;
        wait_cyc(40);
        chk("R6 hold", holdover, 1);
        chk("R6 sel kept", active_sel, 1);
        tune_live = 16'hBEEF;
        wait_cyc(3);
        chk("R9 frozen", held_tune, 16'h1234);

        // Recovery.
        ref_en = 2'b10;
        wait_cyc(80);
        chk("R12 exit hold", holdover, 0);
        chk("R12 sel", active_sel, 1);
        chk("R9 tracks again", held_tune, 16'hBEEF);

        // Software mode on a dead input.
        sel_mode = 2'd0; man_sel = 1'b0;
        wait_cyc(1);
        chk("R7 soft dead", holdover, 1);

        // Pin mode.
        sel_mode = 2'd1; sel_pins = 2'b01;
        wait_cyc(8);
        chk("R4 pin sel", active_sel, 1);
        chk("R4 pin no hold", holdover, 0);
        sel_pins = 2'b10;
        wait_cyc(1);
        chk("R4 pin hold", holdover, 1);
        sel_pins = 2'b00;
        wait_cyc(1);
        chk("R7 pin dead", holdover, 1);
        sel_pins = 2'b01;
        wait_cyc(8);

        // Forced holdover.
        sel_mode = 2'd3;
        wait_cyc(1);
        chk("R8 forced", holdover, 1);
        sel_mode = 2'd2;
        wait_cyc(8);
        chk("R8 recovered", holdover, 0);
        chk("R8 sel", active_sel, 1);

        // Exact settle timing.
        ref_en = 2'b11;
        wait_cyc(80);
        sel_mode = 2'd0; man_sel = 1'b1;
        wait_cyc(8);
        chk("R4 soft sel", active_sel, 1);
        man_sel = 1'b0;
        wait_cyc(4);
        chk("R10 not yet", active_sel, 1);
        wait_cyc(1);
        chk("R10 committed", active_sel, 0);
        chk("R11 div after", ref_div, 100);

        // Random mode, choice and tuning with both inputs valid.
        begin
            logic prev_sel = 1'b0;
            bit   prev_hold = 1'b0;
            logic [15:0] frozen = 16'h0;
            void'($urandom(32'd2024));
            for (int it = 0; it < 40; it++) begin
                logic [1:0]  m  = 2'($urandom % 4);
                logic        ms = 1'($urandom % 2);
                logic [1:0]  pn = 2'($urandom % 4);
                logic [15:0] t  = 16'($urandom);
                bit          eh;
                logic        es;
                sel_mode = m; man_sel = ms; sel_pins = pn; tune_live = t;
                wait_cyc(12);
                eh = exp_hold(m, pn);
                es = exp_sel(m, ms, pn, prev_sel);
                chk("R4 R8 rnd hold", holdover, eh);
                chk("R4 R10 rnd sel", active_sel, es);
                chk("R11 rnd div", ref_div, es ? 200 : 100);
                if (eh) begin
                    if (!prev_hold) frozen = t;
                    chk("R9 rnd frozen", held_tune, frozen);
                end else begin
                    chk("R9 rnd track", held_tune, t);
                end
                prev_hold = eh;
                prev_sel  = es;
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
            $finish;
        end
    end

endmodule